// File: doc/BRIEF.md
# Floating-Point Exception Trap and Default-Result Unit

This block sits at the output of a single-precision floating-point datapath. For every completed operation it decides whether to raise the one trap event or to commit a result. It takes the raw outcome, the operation class, the per-cause condition flags from the datapath, the unrounded sign, and three control fields: the five trap enables, the denormal-flush bit and the rounding mode. If a condition is present but its trap is not enabled, the block sets the matching sticky flag and replaces the raw outcome with the standard default value.

All trap causes share a single request line. The handler learns the reason from a registered cause code. When a trap is taken, the destination write is suppressed, so the destination keeps its old contents. The datapath reports overflow, underflow and inexact as *possibilities*, and the trap decision uses those flags as given. Every output is registered one cycle after the operation-valid strobe.

Top module: `fp_exc_unit`

## Requirements
- R1: With `flush_dn`=0 and `in_denorm`=1, a valid operation traps with cause E (code 1), whatever the enables say. With `flush_dn`=1, a denormal input alone never traps.
- R2: An invalid trap (code 2) is raised when enable bit 4 (V) is 1 and either `cond_inv`=1 or the class is transform (`op_class`=3). A transform with V disabled and no `cond_inv` sets no V flag.
- R3: A divide-by-zero trap (code 3) is raised when enable bit 3 (Z) is 1, `cond_zero`=1 and the class is divide (1) or reciprocal square root (2). For any other class, `cond_zero` is ignored.
- R4: Overflow, underflow and inexact traps (codes 4, 5, 6) are raised when enable bit 2, 1 or 0 respectively is 1 and `cond_ovf`, `cond_unf` or `cond_inx` is 1.
- R5: When several traps apply together, the cause is chosen by priority E, V, Z, O, U, I. A valid operation without a trap reports cause 0.
- R6: `trap_req` and `dest_we` are single-cycle pulses in the cycle after `op_valid`. Exactly one of them is 1 per valid operation, and neither is 1 without one.
- R7: A trapped operation leaves `dest_we`=0 and keeps `result` unchanged.
- R8: On a non-trapped operation, each present condition sets its sticky flag (bit 4 V, 3 Z, 2 O, 1 U, 0 I). Flags hold until cleared through `flag_clr`, and a set wins over a clear in the same cycle.
- R9: Default results are chosen by priority V, Z, O, U, I. The invalid default is 32'h7FC00000. The divide-by-zero default is infinity with the sign of `unr_sign`.
- R10: The overflow default is {sign, 8'hFE, all-ones mantissa} when `rnd_rz`=1 (toward zero), and signed infinity when `rnd_rz`=0 (to nearest).
- R11: The underflow default is {sign, raw bits 30:0} (signed denormal or zero) when `flush_dn`=0, and signed zero when `flush_dn`=1.
- R12: With only the inexact condition present, or with no condition present, `result` is the raw outcome unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation completes this cycle |
| op_class | input | 2 | 0 other, 1 divide, 2 reciprocal square root, 3 transform |
| in_denorm | input | 1 | Some input operand is denormalized |
| cond_inv | input | 1 | Invalid-operation condition |
| cond_zero | input | 1 | Zero divisor or zero root input |
| cond_ovf | input | 1 | Overflow possible |
| cond_unf | input | 1 | Underflow possible |
| cond_inx | input | 1 | Inexact result possible |
| raw_result | input | 32 | Datapath outcome |
| unr_sign | input | 1 | Sign of the unrounded value |
| trap_en | input | 5 | Trap enables, bit 4 V down to bit 0 I |
| flush_dn | input | 1 | Denormal-flush control |
| rnd_rz | input | 1 | 1 round toward zero, 0 round to nearest |
| flag_clr | input | 5 | Software clear of sticky flags |
| trap_req | output | 1 | Trap event pulse |
| trap_cause | output | 3 | 0 none, 1 E, 2 V, 3 Z, 4 O, 5 U, 6 I |
| sticky_flags | output | 5 | Sticky flags, same bit order as enables |
| dest_we | output | 1 | Destination write enable pulse |
| result | output | 32 | Committed result word |

## Verification
The bench targets the places where the priority and qualification rules meet. A denormal with flushing on must not trap, and a design that ignored the flush bit would trap there. A zero-divisor flag on a non-divide class must be ignored; mishandling it would set Z or trap. A transform with V disabled must leave no flag behind. Simultaneous causes must report the highest-priority code, and a wrong order shows up as a different code. The overflow and underflow defaults are tried under both rounding modes and both flush settings: a swapped mode returns infinity where the largest normal belongs, and an unflushed underflow leaks mantissa bits. A trapped cycle is checked for a held result and an unchanged flag set. A clear that lands together with a set must leave the new flag standing.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NCOND   = 5;
  localparam int CAUSE_W = 3;
  localparam int IX_V = 4;
  localparam int IX_Z = 3;
  localparam int IX_O = 2;
  localparam int IX_U = 1;
  localparam int IX_I = 0;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_DIV   = 2'd1,
    CLS_RSQRT = 2'd2,
    CLS_XFORM = 2'd3
  } op_class_e;

  typedef enum logic [CAUSE_W-1:0] {
    CZ_NONE = 3'd0,
    CZ_E    = 3'd1,
    CZ_V    = 3'd2,
    CZ_Z    = 3'd3,
    CZ_O    = 3'd4,
    CZ_U    = 3'd5,
    CZ_I    = 3'd6
  } cause_e;
endpackage

// File: rtl/fpx_trap_eval.sv
module fpx_trap_eval
  import fpx_pkg::*;
(
  input  logic [1:0]          op_class,
  input  logic                in_denorm,
  input  logic                flush_dn,
  input  logic                cond_inv,
  input  logic                cond_zero,
  input  logic                cond_ovf,
  input  logic                cond_unf,
  input  logic                cond_inx,
  input  logic [NCOND-1:0]    trap_en,
  output logic                trap,
  output logic [CAUSE_W-1:0]  cause,
  output logic [NCOND-1:0]    occur
);
  logic is_xform, zero_ok;
  logic [NCOND-1:0] hit;

  always_comb begin
    is_xform   = (op_class == CLS_XFORM);
    zero_ok    = (op_class == CLS_DIV) || (op_class == CLS_RSQRT);
    occur[IX_V] = cond_inv;
    occur[IX_Z] = cond_zero & zero_ok;
    occur[IX_O] = cond_ovf;
    occur[IX_U] = cond_unf;
    occur[IX_I] = cond_inx;
    hit         = trap_en & occur;
    hit[IX_V]   = trap_en[IX_V] & (cond_inv | is_xform);
  end

  // Priority: E first, then V, Z, O, U, I (highest bit index first).
  always_comb begin
    trap  = 1'b0;
    cause = CZ_NONE;
    if (!flush_dn && in_denorm) begin
      trap  = 1'b1;
      cause = CZ_E;
    end else begin
      for (int i = 0; i < NCOND; i++) begin
        if (hit[i]) begin
          trap  = 1'b1;
          cause = CAUSE_W'(CZ_V + (NCOND - 1 - i));
        end
      end
    end
  end
endmodule

// File: rtl/fpx_default_gen.sv
module fpx_default_gen
  import fpx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic [NCOND-1:0]  occur,
  input  logic [DATA_W-1:0] raw,
  input  logic              sign,
  input  logic              flush_dn,
  input  logic              rnd_rz,
  output logic [DATA_W-1:0] dflt
);
  localparam int MAN_W = DATA_W - EXP_W - 1;
  localparam logic [DATA_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [DATA_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
  localparam logic [DATA_W-2:0] MAX_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};

  always_comb begin
    if (occur[IX_V])       dflt = QNAN;
    else if (occur[IX_Z])  dflt = {sign, INF_MAG};
    else if (occur[IX_O])  dflt = rnd_rz ? {sign, MAX_MAG} : {sign, INF_MAG};
    else if (occur[IX_U])  dflt = flush_dn ? {sign, {(DATA_W-1){1'b0}}}
                                           : {sign, raw[DATA_W-2:0]};
    else                   dflt = raw;
  end
endmodule

// File: rtl/fpx_sticky.sv
module fpx_sticky #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_d;

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_comb flags_d[b] = (set_en & set_vec[b]) | (flags[b] & ~clr_vec[b]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[b] <= 1'b0;
      else        flags[b] <= flags_d[b];
    end
  end

  // R8: a flag only rises through a set from a committed operation
  p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags)) != '0) |-> $past(set_en));
  // R8: a set bit is visible after the edge even with a clear on that bit
  p_set_beats_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((flags & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/fp_exc_unit.sv
module fp_exc_unit
  import fpx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [1:0]          op_class,
  input  logic                in_denorm,
  input  logic                cond_inv,
  input  logic                cond_zero,
  input  logic                cond_ovf,
  input  logic                cond_unf,
  input  logic                cond_inx,
  input  logic [DATA_W-1:0]   raw_result,
  input  logic                unr_sign,
  input  logic [NCOND-1:0]    trap_en,
  input  logic                flush_dn,
  input  logic                rnd_rz,
  input  logic [NCOND-1:0]    flag_clr,
  output logic                trap_req,
  output logic [CAUSE_W-1:0]  trap_cause,
  output logic [NCOND-1:0]    sticky_flags,
  output logic                dest_we,
  output logic [DATA_W-1:0]   result
);
  logic                trap_c;
  logic [CAUSE_W-1:0]  cause_c;
  logic [NCOND-1:0]    occur_c;
  logic [DATA_W-1:0]   dflt_c;

  logic                trap_d, we_d;
  logic [CAUSE_W-1:0]  cause_d;
  logic [DATA_W-1:0]   result_d;

  fpx_trap_eval u_eval (
    .op_class  (op_class),
    .in_denorm (in_denorm),
    .flush_dn  (flush_dn),
    .cond_inv  (cond_inv),
    .cond_zero (cond_zero),
    .cond_ovf  (cond_ovf),
    .cond_unf  (cond_unf),
    .cond_inx  (cond_inx),
    .trap_en   (trap_en),
    .trap      (trap_c),
    .cause     (cause_c),
    .occur     (occur_c)
  );

  fpx_default_gen #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_dflt (
    .occur    (occur_c),
    .raw      (raw_result),
    .sign     (unr_sign),
    .flush_dn (flush_dn),
    .rnd_rz   (rnd_rz),
    .dflt     (dflt_c)
  );

  fpx_sticky #(.N(NCOND)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (we_d),
    .set_vec (occur_c),
    .clr_vec (flag_clr),
    .flags   (sticky_flags)
  );

  // next state
  always_comb begin
    trap_d   = op_valid & trap_c;
    we_d     = op_valid & ~trap_c;
    cause_d  = op_valid ? cause_c : trap_cause;
    result_d = we_d ? dflt_c : result;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req   <= 1'b0;
      dest_we    <= 1'b0;
      trap_cause <= '0;
      result     <= '0;
    end else begin
      trap_req   <= trap_d;
      dest_we    <= we_d;
      trap_cause <= cause_d;
      result     <= result_d;
    end
  end

  // R6: one pulse per valid operation, none otherwise
  p_one_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (trap_req ^ dest_we));
  p_no_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!trap_req && !dest_we));
  // R7: a trap holds the destination
  p_trap_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (!dest_we && $stable(result)));
  // R5: a trap always carries a cause code
  p_trap_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_cause != CZ_NONE));
  // R1: unflushed denormal input traps as E
  p_denorm_e_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flush_dn && in_denorm) |=> (trap_req && trap_cause == CZ_E));
  // R9: an untrapped invalid condition commits the quiet NaN
  p_inv_qnan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cond_inv && !trap_c) |=> (result == {1'b0, {EXP_W{1'b1}}, 1'b1, {(DATA_W-EXP_W-2){1'b0}}}));
endmodule

// File: tb/fp_exc_unit_test.sv
`timescale 1ns/100ps
module fp_exc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_class;
  logic        in_denorm, cond_inv, cond_zero, cond_ovf, cond_unf, cond_inx;
  logic [31:0] raw_result;
  logic        unr_sign;
  logic [4:0]  trap_en;
  logic        flush_dn, rnd_rz;
  logic [4:0]  flag_clr;
  logic        trap_req, dest_we;
  logic [2:0]  trap_cause;
  logic [4:0]  sticky_flags;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  logic [4:0]  m_flags;
  logic [31:0] m_result;
  logic [2:0]  m_cause;

  always #2.5 clk = ~clk;

  fp_exc_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .in_denorm(in_denorm), .cond_inv(cond_inv), .cond_zero(cond_zero),
    .cond_ovf(cond_ovf), .cond_unf(cond_unf), .cond_inx(cond_inx),
    .raw_result(raw_result), .unr_sign(unr_sign), .trap_en(trap_en),
    .flush_dn(flush_dn), .rnd_rz(rnd_rz), .flag_clr(flag_clr),
    .trap_req(trap_req), .trap_cause(trap_cause), .sticky_flags(sticky_flags),
    .dest_we(dest_we), .result(result)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 0; op_class = 0; in_denorm = 0; cond_inv = 0; cond_zero = 0;
    cond_ovf = 0; cond_unf = 0; cond_inx = 0; raw_result = 0; unr_sign = 0;
    trap_en = 0; flush_dn = 0; rnd_rz = 0; flag_clr = 0;
  endtask

  // reference model computed from the requirements
  task automatic model(output logic e_trap, output logic e_we, output logic [2:0] e_cause,
                       output logic [31:0] e_res, output logic [4:0] e_flags);
    logic [4:0] occ, hit;
    logic s;
    s = unr_sign;
    occ = {cond_inv, cond_zero && (op_class == 2'd1 || op_class == 2'd2),
           cond_ovf, cond_unf, cond_inx};
    hit = occ & trap_en;
    hit[4] = trap_en[4] && (cond_inv || op_class == 2'd3);
    e_trap = 0; e_cause = m_cause; e_we = 0; e_res = m_result;
    if (op_valid) begin
      e_cause = 3'd0;
      if (!flush_dn && in_denorm) begin e_trap = 1; e_cause = 3'd1; end
      else if (hit[4]) begin e_trap = 1; e_cause = 3'd2; end
      else if (hit[3]) begin e_trap = 1; e_cause = 3'd3; end
      else if (hit[2]) begin e_trap = 1; e_cause = 3'd4; end
      else if (hit[1]) begin e_trap = 1; e_cause = 3'd5; end
      else if (hit[0]) begin e_trap = 1; e_cause = 3'd6; end
      e_we = !e_trap;
    end
    e_flags = m_flags & ~flag_clr;
    if (e_we) begin
      e_flags = e_flags | occ;
      if (occ[4])      e_res = 32'h7FC0_0000;
      else if (occ[3]) e_res = {s, 8'hFF, 23'h0};
      else if (occ[2]) e_res = rnd_rz ? {s, 8'hFE, 23'h7FFFFF} : {s, 8'hFF, 23'h0};
      else if (occ[1]) e_res = flush_dn ? {s, 31'h0} : {s, raw_result[30:0]};
      else             e_res = raw_result;
    end
  endtask

  // inputs already set at a negedge; advance one cycle and compare
  task automatic step(input string tag);
    logic t, w; logic [2:0] c; logic [31:0] r; logic [4:0] f;
    model(t, w, c, r, f);
    @(negedge clk);
    chk(trap_req == t,       {tag, " trap_req"},  {31'h0, trap_req}, {31'h0, t});
    chk(dest_we == w,        {tag, " dest_we"},   {31'h0, dest_we},  {31'h0, w});
    chk(trap_cause == c,     {tag, " cause"},     {29'h0, trap_cause}, {29'h0, c});
    chk(result == r,         {tag, " result"},    result, r);
    chk(sticky_flags == f,   {tag, " flags"},     {27'h0, sticky_flags}, {27'h0, f});
    m_flags = f; m_result = r; m_cause = c;
    idle_inputs();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h1F2E3D;
    void'($urandom(seed));
    idle_inputs();
    rst_n = 0;
    m_flags = 0; m_result = 0; m_cause = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R6 reset state
    chk(!trap_req && !dest_we && trap_cause == 0 && sticky_flags == 0 && result == 0,
        "R6 reset state", {27'h0, sticky_flags}, 32'h0);

    // R1: denormal, no enables, flush off -> E
    op_valid = 1; in_denorm = 1; raw_result = 32'h1234_5678; step("R1 denorm trap");
    // R1: flush on -> no trap, raw passes (R12)
    op_valid = 1; in_denorm = 1; flush_dn = 1; raw_result = 32'h3F80_0000; step("R1 flushed denorm R12");
    // R2: transform with V enabled
    op_valid = 1; op_class = 3; trap_en = 5'b10000; raw_result = 32'h1; step("R2 xform trap");
    // R2: transform with V disabled, no flag
    op_valid = 1; op_class = 3; raw_result = 32'h2; step("R2 xform no enable");
    // R3: zero flag on other class ignored even with Z enabled
    op_valid = 1; op_class = 0; cond_zero = 1; trap_en = 5'b01000; raw_result = 32'h4; step("R3 zero ignored");
    // R3: divide by zero trap
    op_valid = 1; op_class = 1; cond_zero = 1; trap_en = 5'b01000; step("R3 div zero trap");
    // R9: rsqrt zero untrapped -> signed infinity
    op_valid = 1; op_class = 2; cond_zero = 1; unr_sign = 1; step("R9 zero default");
    // R7: trap holds result (previous was -inf)
    op_valid = 1; cond_ovf = 1; trap_en = 5'b00100; raw_result = 32'hDEAD_BEEF; step("R7 R4 ovf trap holds");
    // R10: overflow defaults
    op_valid = 1; cond_ovf = 1; rnd_rz = 1; unr_sign = 1; step("R10 ovf rz");
    op_valid = 1; cond_ovf = 1; rnd_rz = 0; step("R10 ovf rn");
    // R11: underflow defaults
    op_valid = 1; cond_unf = 1; unr_sign = 1; raw_result = 32'h0000_0ABC; step("R11 unf noflush");
    op_valid = 1; cond_unf = 1; flush_dn = 1; raw_result = 32'h0000_0ABC; step("R11 unf flush");
    // R5: priority, all causes at once
    op_valid = 1; op_class = 1; cond_inv = 1; cond_zero = 1; cond_ovf = 1; cond_unf = 1; cond_inx = 1;
    trap_en = 5'b11111; in_denorm = 1; step("R5 E first");
    op_valid = 1; op_class = 1; cond_zero = 1; cond_ovf = 1; cond_unf = 1; cond_inx = 1;
    trap_en = 5'b01111; step("R5 Z over O");
    op_valid = 1; cond_unf = 1; cond_inx = 1; trap_en = 5'b00011; step("R5 U over I");
    op_valid = 1; cond_inx = 1; trap_en = 5'b00001; step("R4 inexact trap");
    // R9 R12: invalid qnan, then inexact alone passes raw
    op_valid = 1; cond_inv = 1; cond_inx = 1; step("R9 qnan");
    op_valid = 1; cond_inx = 1; raw_result = 32'h4049_0FDB; step("R12 inexact raw");
    // R8: clear colliding with set
    op_valid = 1; cond_inx = 1; flag_clr = 5'b11111; step("R8 set beats clear");
    flag_clr = 5'b00001; step("R8 clear only");
    // R6: idle cycle
    step("R6 idle");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      op_valid   = ($urandom % 4) != 0;
      op_class   = 2'($urandom);
      in_denorm  = ($urandom % 8) == 0;
      cond_inv   = ($urandom % 5) == 0;
      cond_zero  = ($urandom % 4) == 0;
      cond_ovf   = ($urandom % 4) == 0;
      cond_unf   = ($urandom % 4) == 0;
      cond_inx   = ($urandom % 3) == 0;
      raw_result = $urandom;
      unr_sign   = 1'($urandom);
      trap_en    = 5'($urandom) & 5'($urandom);
      flush_dn   = 1'($urandom);
      rnd_rz     = 1'($urandom);
      flag_clr   = (($urandom % 8) == 0) ? 5'($urandom) : 5'h0;
      step("R1 R2 R3 R4 R5 R8 R9 R10 R11 R12 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule